// File: doc/BRIEF.md
# Buffered Serial Transmitter

This block is the outbound half of an asynchronous serial port. A producer hands it whole bytes with a one-cycle write strobe. Each byte enters a 16-entry queue, moves into a single-byte staging register, and then into a 12-bit frame register. There it is framed and shifted onto one serial line. Each stage pulls a new byte as soon as the stage after it has room, so the producer can post a burst of bytes and leave the block to send them in order.

The frame shape comes from a small set of configuration inputs: word length from five to eight bits, parity on or off, even or odd parity, and one or two stop bits. An external baud tick, one clock wide, sets the pace. The line changes only on a tick. The configuration is captured when a byte enters the frame register, so the host may change it for the next byte while the current one is still going out. A queue-full flag protects the queue. An all-empty status shows that nothing is left waiting or in flight.

Top module: `uart_tx_path`

## Requirements
- R1: After synchronous reset, `tx_out` is high, `tx_empty` is high and `fifo_full` is low.
- R2: A frame is, in order: one low start bit, the data bits with the least significant first, the optional parity bit, then the stop bits, which are high. Whenever no frame is being sent, the line rests high.
- R3: `cfg_word_len` selects the number of data bits. The encoding is 0 for five bits, 1 for six, 2 for seven and 3 for eight. Only that many low-order bits of the byte are sent.
- R4: When `cfg_parity_en` is 1, one parity bit follows the data. With `cfg_parity_odd` = 0, the data bits plus the parity bit hold an even number of ones. With `cfg_parity_odd` = 1, they hold an odd number.
- R5: `cfg_two_stop` = 0 gives one stop bit and `cfg_two_stop` = 1 gives two.
- R6: `tx_out` changes only in the cycle after a clock edge at which `baud_tick` is high, so each bit lasts exactly one tick period.
- R7: When another byte is waiting, its start bit goes out on the tick that ends the previous frame's last stop bit, with no idle bit between the two frames.
- R8: Bytes are sent in the order written. The block holds 18 bytes: 16 in the queue, 1 in the staging register and 1 in the frame register. `fifo_full` is high while the queue holds 16 bytes, and a write made while it is high is dropped.
- R9: The configuration is sampled when a byte is loaded into the frame register. A later change does not alter the frame in progress.
- R10: `tx_empty` is high one cycle after the queue, the staging register and the frame register are all empty. It is low while any byte is waiting or being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one byte per cycle it is high |
| wr_data | input | 8 | Byte to send |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| cfg_word_len | input | 2 | Data bits: 0=5, 1=6, 2=7, 3=8 |
| cfg_parity_en | input | 1 | Parity bit present |
| cfg_parity_odd | input | 1 | 1 selects odd parity, 0 even |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| tx_out | output | 1 | Serial line, high at rest |
| fifo_full | output | 1 | Queue holds 16 bytes |
| tx_empty | output | 1 | Nothing waiting or in flight |

## Verification
The assertions assume that `baud_tick` is a pulse one clock wide. They also assume that a stage takes a byte only in a cycle when it reports empty. No rule is placed on when the configuration inputs may change. The stimulus sends ticks four clocks apart. It changes the configuration between ticks, including once during a frame, to exercise the sampling point. Writes are one-cycle strobes, and one overfill write is made on purpose against a full queue.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam int DATA_W  = 8;
  localparam int FRAME_W = 12;
  localparam int CNT_W   = 4;

  typedef struct packed {
    logic [1:0] word_len;
    logic       parity_en;
    logic       parity_odd;
    logic       two_stop;
  } tx_cfg_t;

  // Bit 0 is sent first; unused upper positions stay high.
  function automatic logic [FRAME_W-1:0] build_frame(input logic [DATA_W-1:0] d,
                                                     input tx_cfg_t c);
    logic [FRAME_W-1:0] f;
    logic               p;
    int                 nd;
    nd   = int'(c.word_len) + 5;
    f    = '1;
    f[0] = 1'b0;
    p    = c.parity_odd;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < nd) begin
        f[1+i] = d[i];
        p      = p ^ d[i];
      end
    end
    if (c.parity_en) f[1+nd] = p;
    return f;
  endfunction

  function automatic logic [CNT_W-1:0] frame_len(input tx_cfg_t c);
    return CNT_W'(7) + {{(CNT_W-2){1'b0}}, c.word_len}
         + {{(CNT_W-1){1'b0}}, c.parity_en}
         + {{(CNT_W-1){1'b0}}, c.two_stop};
  endfunction
endpackage

// File: rtl/tx_fifo.sv
module tx_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             pop,
  output logic [WIDTH-1:0] rd_data,
  output logic             empty,
  output logic             full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count;
  logic             push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign push    = wr_en && !full;
  assign do_pop  = pop && !empty;
  assign rd_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wr_data;
  end

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push)   wr_ptr <= bump(wr_ptr);
      if (do_pop) rd_ptr <= bump(rd_ptr);
      case ({push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
    (full && wr_en) |=> $stable(wr_ptr));
  p_count_bound_r8: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
endmodule

// File: rtl/tx_hold.sv
module tx_hold #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fifo_empty,
  input  logic [WIDTH-1:0] fifo_data,
  input  logic             take,
  output logic             pop,
  output logic             hold_full,
  output logic [WIDTH-1:0] hold_data
);
  assign pop = !hold_full && !fifo_empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_full <= 1'b0;
      hold_data <= '0;
    end else if (pop) begin
      hold_full <= 1'b1;
      hold_data <= fifo_data;
    end else if (take) begin
      hold_full <= 1'b0;
    end
  end

  p_hold_keep_r8: assert property (@(posedge clk) disable iff (rst)
    (hold_full && !take) |=> (hold_full && $stable(hold_data)));
endmodule

// File: rtl/tx_shifter.sv
module tx_shifter
  import uart_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              baud_tick,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_data,
  input  tx_cfg_t           cfg,
  output logic              take,
  output logic              sh_empty,
  output logic              tx_out
);
  logic [FRAME_W-1:0] shreg, src_bits;
  logic [CNT_W-1:0]   bits_left, src_cnt;

  assign sh_empty = (bits_left == '0);
  assign take     = hold_full && sh_empty;

  always_comb begin
    src_bits = shreg;
    src_cnt  = bits_left;
    if (take) begin
      src_bits = build_frame(hold_data, cfg);
      src_cnt  = frame_len(cfg);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg     <= '1;
      bits_left <= '0;
      tx_out    <= 1'b1;
    end else if (baud_tick && (src_cnt != '0)) begin
      tx_out    <= src_bits[0];
      shreg     <= {1'b1, src_bits[FRAME_W-1:1]};
      bits_left <= src_cnt - 1'b1;
    end else begin
      if (baud_tick) tx_out <= 1'b1;
      shreg     <= src_bits;
      bits_left <= src_cnt;
    end
  end

  p_tick_paced_r6: assert property (@(posedge clk) disable iff (rst)
    !baud_tick |=> $stable(tx_out));
  p_start_low_r2: assert property (@(posedge clk) disable iff (rst)
    (baud_tick && take) |=> !tx_out);
  p_rest_high_r2: assert property (@(posedge clk) disable iff (rst)
    (baud_tick && sh_empty && !take) |=> tx_out);
endmodule

// File: rtl/uart_tx_path.sv
module uart_tx_path #(
  parameter int FIFO_DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       baud_tick,
  input  logic [1:0] cfg_word_len,
  input  logic       cfg_parity_en,
  input  logic       cfg_parity_odd,
  input  logic       cfg_two_stop,
  output logic       tx_out,
  output logic       fifo_full,
  output logic       tx_empty
);
  import uart_tx_pkg::*;

  tx_cfg_t           cfg;
  logic [DATA_W-1:0] q_data, h_data;
  logic              q_empty, pop, h_full, take, sh_empty;

  assign cfg = '{word_len: cfg_word_len, parity_en: cfg_parity_en,
                 parity_odd: cfg_parity_odd, two_stop: cfg_two_stop};

  tx_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(DATA_W)) u_fifo (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .pop(pop),
    .rd_data(q_data), .empty(q_empty), .full(fifo_full));

  tx_hold #(.WIDTH(DATA_W)) u_hold (
    .clk(clk), .rst(rst), .fifo_empty(q_empty), .fifo_data(q_data),
    .take(take), .pop(pop), .hold_full(h_full), .hold_data(h_data));

  tx_shifter u_shift (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .hold_full(h_full),
    .hold_data(h_data), .cfg(cfg), .take(take), .sh_empty(sh_empty),
    .tx_out(tx_out));

  always_ff @(posedge clk) begin
    if (rst) tx_empty <= 1'b1;
    else     tx_empty <= q_empty && !h_full && sh_empty;
  end

  p_empty_line_high_r10: assert property (@(posedge clk) disable iff (rst)
    tx_empty |-> tx_out);
endmodule

// File: tb/tb_uart_tx_path.sv
module tb_uart_tx_path;
  localparam int CLK_NS = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       baud_tick = 1'b0;
  logic [1:0] cfg_word_len = 2'd3;
  logic       cfg_parity_en = 1'b0;
  logic       cfg_parity_odd = 1'b0;
  logic       cfg_two_stop = 1'b0;
  logic       tx_out, fifo_full, tx_empty;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;

  uart_tx_path dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .baud_tick(baud_tick), .cfg_word_len(cfg_word_len),
    .cfg_parity_en(cfg_parity_en), .cfg_parity_odd(cfg_parity_odd),
    .cfg_two_stop(cfg_two_stop), .tx_out(tx_out), .fifo_full(fifo_full),
    .tx_empty(tx_empty));

  // vector: [12:5] byte, [4:3] word length code, [2] parity on, [1] odd, [0] two stop
  localparam logic [12:0] VEC [6] = '{
    {8'hA5, 2'd3, 1'b0, 1'b0, 1'b0},
    {8'h3C, 2'd3, 1'b1, 1'b0, 1'b0},
    {8'h3D, 2'd3, 1'b1, 1'b1, 1'b1},
    {8'hFF, 2'd0, 1'b1, 1'b0, 1'b0},
    {8'h96, 2'd1, 1'b1, 1'b1, 1'b1},
    {8'h81, 2'd2, 1'b0, 1'b0, 1'b1}
  };

  function automatic int exp_len(input logic [4:0] c);
    return 1 + (5 + int'(c[4:3])) + int'(c[2]) + 1 + int'(c[0]);
  endfunction

  function automatic logic exp_bit(input logic [7:0] d, input logic [4:0] c, input int k);
    int nd;
    int ones;
    nd = 5 + int'(c[4:3]);
    if (k == 0) return 1'b0;
    if (k <= nd) return d[k-1];
    if (c[2] && k == nd + 1) begin
      ones = 0;
      for (int i = 0; i < nd; i++) ones += int'(d[i]);
      return c[1] ? ~ones[0] : ones[0];
    end
    return 1'b1;
  endfunction

  task automatic check(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", what, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [4:0] c);
    cfg_word_len   = c[4:3];
    cfg_parity_en  = c[2];
    cfg_parity_odd = c[1];
    cfg_two_stop   = c[0];
  endtask

  task automatic write_byte(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tick(output logic b);
    @(negedge clk);
    baud_tick = 1'b1;
    @(negedge clk);
    baud_tick = 1'b0;
    b = tx_out;
    repeat (2) @(negedge clk);
  endtask

  task automatic check_bits(input logic [7:0] d, input logic [4:0] c,
                            input int from, input int upto, input string tag);
    logic b;
    for (int k = from; k < upto; k++) begin
      tick(b);
      check(b, exp_bit(d, c, k), $sformatf("%s byte %02h bit %0d", tag, d, k));
    end
  endtask

  task automatic check_idle(input string tag);
    logic b;
    tick(b);
    check(b, 1'b1, tag);
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic b;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(tx_out, 1'b1, "R1 reset tx_out");
    check(tx_empty, 1'b1, "R1 reset tx_empty");
    check(fifo_full, 1'b0, "R1 reset fifo_full");
    // line rests high while ticks arrive with nothing queued (R2, R6)
    check_idle("R2 idle line");

    // table walk: R2 R3 R4 R5
    for (int v = 0; v < 6; v++) begin
      set_cfg(VEC[v][4:0]);
      write_byte(VEC[v][12:5]);
      repeat (3) @(negedge clk);
      check(tx_empty, 1'b0, "R10 busy after write");
      check_bits(VEC[v][12:5], VEC[v][4:0], 0, exp_len(VEC[v][4:0]), "R2/R3/R4/R5");
      check_idle("R2 rest after frame");
      check(tx_empty, 1'b1, "R10 empty after frame");
    end

    // R6: no tick, no change on the line
    set_cfg({2'd3, 1'b0, 1'b0, 1'b0});
    write_byte(8'h00);
    repeat (10) @(negedge clk);
    check(tx_out, 1'b1, "R6 line waits for tick");
    check_bits(8'h00, {2'd3, 3'b000}, 0, 10, "R6");
    check_idle("R6 rest");

    // R9: config changed mid-frame
    set_cfg({2'd3, 1'b1, 1'b0, 1'b1});
    write_byte(8'h5B);
    repeat (3) @(negedge clk);
    check_bits(8'h5B, {2'd3, 3'b101}, 0, 3, "R9 before change");
    set_cfg({2'd0, 1'b0, 1'b1, 1'b0});
    check_bits(8'h5B, {2'd3, 3'b101}, 3, 12, "R9 after change");
    check_idle("R9 rest");

    // R7: back-to-back frames, second start bit on the following tick
    set_cfg({2'd0, 1'b0, 1'b0, 1'b0});
    write_byte(8'h1F);
    write_byte(8'h0A);
    repeat (3) @(negedge clk);
    check_bits(8'h1F, {2'd0, 3'b000}, 0, 7, "R7 first");
    tick(b);
    check(b, 1'b0, "R7 second start bit without gap");
    check_bits(8'h0A, {2'd0, 3'b000}, 1, 7, "R7 second");
    check_idle("R7 rest");

    // R8: fill 18 bytes, overfill ignored, order kept
    set_cfg({2'd3, 1'b0, 1'b0, 1'b0});
    for (int i = 0; i < 18; i++) write_byte(8'h10 + 8'(i));
    repeat (3) @(negedge clk);
    check(fifo_full, 1'b1, "R8 full after 18 writes");
    write_byte(8'hEE);
    for (int i = 0; i < 18; i++)
      check_bits(8'h10 + 8'(i), {2'd3, 3'b000}, 0, 10, "R8 order");
    check(fifo_full, 1'b0, "R8 not full after drain");
    check_idle("R8 dropped byte not sent");
    check(tx_empty, 1'b1, "R10 empty after drain");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule